// File: doc/BRIEF.md
# Page-Split Descriptor List Generator

This block turns a single transfer request, given as a starting byte address and a byte count, into a chain of (start, length) descriptors. No descriptor may straddle a page boundary. The first descriptor runs from the start address to the end of its page, or covers the whole transfer if that is shorter. Every later descriptor begins on a page boundary and covers one full page or whatever bytes are left.

Descriptors leave the block one per clock on a valid/ready stream. Each is packed as an 8-byte little-endian record. When the last record has been taken, a one-cycle completion pulse reports how many records were produced, and that count can fill the descriptor-count field of a command block. The list has a fixed capacity of 33 entries. A transfer that needs more raises a one-cycle error pulse in place of the 34th record, and the block goes back to idle.

A new request is taken only while the block is idle. The output record stays frozen for as long as the consumer holds ready low.

Top module: `sg_list_builder`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `desc_valid`, `done` and `err` are 0 and `req_ready` is 1. This holds even if reset arrives in the middle of a list.
- R2: `req_ready` is 1 only while idle. While a list is being emitted, `req_ready` is 0 and any activity on `req_valid`, `req_addr` or `req_len` leaves the emitted records unchanged.
- R3: The first record has start equal to the request address. Its length is `PAGE_BYTES - (addr mod PAGE_BYTES)`, capped at the request length.
- R4: Each later record starts at the byte just after the previous record, which is page-aligned. Its length is min(`PAGE_BYTES`, bytes remaining). No record crosses a page boundary and no record has length 0.
- R5: The record layout is: `desc_data[31:0]` holds the start address and `desc_data[63:32]` holds the length. Byte k of each field sits at bits 8k+7..8k, so the least-significant byte comes first.
- R6: While `desc_valid` is 1 and `desc_ready` is 0, the next cycle still has `desc_valid` at 1 with `desc_data` unchanged.
- R7: The cycle after the handshake of the last record, `done` pulses high for one cycle and `done_count` equals the number of records emitted.
- R8: A request with length 0 emits no record. In the cycle after acceptance, `done` is 1 with `done_count` equal to 0.
- R9: When 33 records have been taken and bytes still remain, `err` pulses high for one cycle in the following cycle. No 34th record appears, `done` stays 0, and the block returns to idle.
- R10: A record is presented in the cycle right after acceptance. With `desc_ready` held high, a new record is presented every cycle until the end of the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Buffer start byte address |
| req_len | input | 32 | Transfer length in bytes |
| desc_valid | output | 1 | Record on `desc_data` is valid |
| desc_ready | input | 1 | Consumer takes the record this cycle |
| desc_data | output | 64 | Packed record: start address in the low word, length in the high word, little-endian |
| done | output | 1 | One-cycle pulse when the list is complete |
| done_count | output | 6 | Number of records in the completed list |
| err | output | 1 | One-cycle pulse when the list would exceed 33 entries |

## Verification
Requests are tried in several forms: page-aligned starts spanning whole pages, a start and end that both fall inside one page, a start one byte before a boundary with a ragged tail, and a zero length. Together these separate the first-fragment rule from the full-page rule and from the remainder cap. Lengths that need exactly 33 entries, reached by two different alignments, are set against lengths one byte larger. This tells a correct limit apart from an off-by-one in either direction. A buffer ending at the top of the address space checks that address wrap does not disturb the length. Consumer stalls and junk traffic on the request side during emission show whether the record holds steady and whether the request side is properly locked out.

// File: rtl/sg_list_pkg.sv
package sg_list_pkg;
  // Width of each record field (start address and length); fixed by the record layout.
  localparam int unsigned FIELD_W = 32;
  localparam int unsigned REC_W   = 2 * FIELD_W;
  localparam int unsigned LANES   = FIELD_W / 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/sg_frag_calc.sv
// Length of the next fragment: the room left in the current page, capped at
// the bytes still outstanding. PAGE_BYTES must be a power of two.
module sg_frag_calc #(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned LEN_W      = 32,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic [OFF_W-1:0] page_off,
  input  logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] frag_len
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room     = LEN_W'(PAGE_BYTES) - {{(LEN_W-OFF_W){1'b0}}, page_off};
    frag_len = (room < remain) ? room : remain;
  end
endmodule

// File: rtl/sg_record_pack.sv
// Packs one (start, length) pair into a little-endian record, lane by lane.
module sg_record_pack
  import sg_list_pkg::*;
(
  input  logic [FIELD_W-1:0] start,
  input  logic [FIELD_W-1:0] len,
  output logic [REC_W-1:0]   rec
);
  for (genvar b = 0; b < int'(LANES); b++) begin : g_lane
    assign rec[8*b +: 8]           = start[8*b +: 8];
    assign rec[FIELD_W + 8*b +: 8] = len[8*b +: 8];
  end
endmodule

// File: rtl/sg_seq_ctrl.sv
// Sequencer: takes requests, walks the buffer a fragment at a time, registers
// each record, counts entries and enforces the list capacity.
module sg_seq_ctrl
  import sg_list_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 33,
  localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FIELD_W-1:0] req_addr,
  input  logic [FIELD_W-1:0] req_len,
  output logic [FIELD_W-1:0] calc_addr,
  output logic [FIELD_W-1:0] calc_remain,
  input  logic [FIELD_W-1:0] frag_len,
  input  logic [REC_W-1:0]   rec_in,
  input  logic               desc_ready,
  output logic               desc_valid,
  output logic [REC_W-1:0]   desc_data,
  output logic               done,
  output logic [CNT_W-1:0]   done_count,
  output logic               err
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENTRIES);

  seq_state_t         state;
  logic [FIELD_W-1:0] cur_addr;
  logic [FIELD_W-1:0] remain;
  logic [CNT_W-1:0]   count;
  logic               fire;

  assign req_ready   = (state == ST_IDLE);
  assign fire        = desc_valid && desc_ready;
  assign calc_addr   = (state == ST_IDLE) ? req_addr : cur_addr;
  assign calc_remain = (state == ST_IDLE) ? req_len  : remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      count      <= '0;
      desc_valid <= 1'b0;
      desc_data  <= '0;
      done       <= 1'b0;
      done_count <= '0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_len == '0) begin
              done       <= 1'b1;
              done_count <= '0;
            end else begin
              desc_valid <= 1'b1;
              desc_data  <= rec_in;
              cur_addr   <= req_addr + frag_len;
              remain     <= req_len - frag_len;
              count      <= CNT_W'(1);
              state      <= ST_EMIT;
            end
          end
        end
        ST_EMIT: begin
          if (fire) begin
            if (remain == '0) begin
              desc_valid <= 1'b0;
              done       <= 1'b1;
              done_count <= count;
              state      <= ST_IDLE;
            end else if (count == CNT_MAX) begin
              desc_valid <= 1'b0;
              err        <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              desc_data <= rec_in;
              cur_addr  <= cur_addr + frag_len;
              remain    <= remain - frag_len;
              count     <= count + CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a stalled record is held unchanged.
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_data)));

  // R2: no new request can be taken while a record is pending.
  assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> !req_ready);

  // R8: zero-length request finishes at once with an empty list.
  assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && req_len == '0) |=> (done && done_count == '0 && !desc_valid));

  // R7: the final handshake is followed by the completion pulse.
  assert_done_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && remain == '0) |=> (done && !err && req_ready));

  // R9: capacity reached with bytes left gives an error and no further record.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (fire && remain != '0 && count == CNT_MAX) |=> (err && !done && !desc_valid));

  // R9: the entry count never leaves its legal range while emitting.
  assert_count_range_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EMIT) |-> (count != '0 && count <= CNT_MAX));
endmodule

// File: rtl/sg_list_builder.sv
module sg_list_builder
  import sg_list_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 4096,
  parameter int unsigned MAX_ENTRIES = 33,
  localparam int unsigned OFF_W      = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FIELD_W-1:0] req_addr,
  input  logic [FIELD_W-1:0] req_len,
  output logic               desc_valid,
  input  logic               desc_ready,
  output logic [REC_W-1:0]   desc_data,
  output logic               done,
  output logic [CNT_W-1:0]   done_count,
  output logic               err
);
  logic [FIELD_W-1:0] calc_addr;
  logic [FIELD_W-1:0] calc_remain;
  logic [FIELD_W-1:0] frag_len;
  logic [REC_W-1:0]   rec;

  sg_frag_calc #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(FIELD_W)) u_calc (
    .page_off (calc_addr[OFF_W-1:0]),
    .remain   (calc_remain),
    .frag_len (frag_len)
  );

  sg_record_pack u_pack (
    .start (calc_addr),
    .len   (frag_len),
    .rec   (rec)
  );

  sg_seq_ctrl #(.MAX_ENTRIES(MAX_ENTRIES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .calc_addr   (calc_addr),
    .calc_remain (calc_remain),
    .frag_len    (frag_len),
    .rec_in      (rec),
    .desc_ready  (desc_ready),
    .desc_valid  (desc_valid),
    .desc_data   (desc_data),
    .done        (done),
    .done_count  (done_count),
    .err         (err)
  );

  // End of each emitted record relative to its page start.
  logic [FIELD_W:0] rec_end;
  assign rec_end = {{(FIELD_W+1-OFF_W){1'b0}}, desc_data[OFF_W-1:0]}
                 + {1'b0, desc_data[REC_W-1:FIELD_W]};

  // R4: a valid record is non-empty and stays inside one page.
  assert_in_page_R4: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_data[REC_W-1:FIELD_W] != '0 && rec_end <= (FIELD_W+1)'(PAGE_BYTES)));

  // R7, R9: completion and error never coincide.
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
endmodule

// File: tb/sg_list_builder_test.sv
module sg_list_builder_test;
  localparam int PAGE = 4096;
  localparam int MAXE = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_len = '0;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic [63:0] desc_data;
  logic        done;
  logic [5:0]  done_count;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  sg_list_builder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_data(desc_data), .done(done),
    .done_count(done_count), .err(err)
  );

  // {addr[31:0], len[31:0], count[5:0], err, stall, noise}
  localparam logic [72:0] VEC [11] = '{
    {32'h0000_1000, 32'h0000_3000, 6'd3,  1'b0, 1'b0, 1'b0},
    {32'h0000_1234, 32'h0000_0010, 6'd1,  1'b0, 1'b1, 1'b0},
    {32'h0000_1FF0, 32'h0000_0020, 6'd2,  1'b0, 1'b0, 1'b1},
    {32'h0000_0FFF, 32'h0000_2002, 6'd4,  1'b0, 1'b1, 1'b1},
    {32'h0000_0000, 32'h0000_0000, 6'd0,  1'b0, 1'b0, 1'b0},
    {32'h0000_0000, 32'h0002_1000, 6'd33, 1'b0, 1'b0, 1'b0},
    {32'h0000_0FFF, 32'h0002_0001, 6'd33, 1'b0, 1'b1, 1'b0},
    {32'h0000_0FFF, 32'h0002_0002, 6'd33, 1'b1, 1'b0, 1'b0},
    {32'h0000_5000, 32'h0002_1001, 6'd33, 1'b1, 1'b1, 1'b1},
    {32'hFFFF_F800, 32'h0000_0800, 6'd1,  1'b0, 1'b0, 1'b0},
    {32'h0000_0ABC, 32'h0000_0001, 6'd1,  1'b0, 1'b0, 1'b1}
  };

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  task automatic run_case(input logic [31:0] addr, input logic [31:0] len,
                          input int exp_cnt, input bit exp_err,
                          input bit stall, input bit noise);
    logic [31:0] m_addr;
    logic [31:0] m_rem;
    longint room;
    longint flen;
    int m_n;
    int cyc;
    bit fin;
    m_addr = addr; m_rem = len; m_n = 0; cyc = 0; fin = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "idle ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_len = len; desc_ready = 1'b1;
    @(negedge clk);
    if (noise) begin
      req_addr = ~addr; req_len = 32'h0000_0005;
    end else begin
      req_valid = 1'b0;
    end
    while (!fin && cyc < 400) begin
      if (m_rem == 0 || m_n == MAXE) begin
        if (!exp_err) begin
          chk(done == 1'b1, "R7", "done pulse", done, 1);
          chk(done_count == 6'(exp_cnt), (exp_cnt == 0) ? "R8" : "R7", "done_count",
              done_count, exp_cnt);
          chk(err == 1'b0, "R9", "no error on fitting list", err, 0);
        end else begin
          chk(err == 1'b1, "R9", "overflow error", err, 1);
          chk(done == 1'b0, "R9", "no done on overflow", done, 0);
        end
        chk(desc_valid == 1'b0, "R9", "no extra record", desc_valid, 0);
        fin = 1;
      end else begin
        chk(desc_valid == 1'b1, (cyc == 0) ? "R10" : "R6", "record present", desc_valid, 1);
        chk(req_ready == 1'b0, "R2", "busy while emitting", req_ready, 0);
        room = longint'(PAGE) - longint'(m_addr % PAGE);
        flen = (room < longint'(m_rem)) ? room : longint'(m_rem);
        chk(desc_data[31:0] == m_addr, (m_n == 0) ? "R3" : "R4", "record start",
            desc_data[31:0], m_addr);
        chk(longint'(desc_data[63:32]) == flen, (m_n == 0) ? "R3" : "R4", "record length",
            desc_data[63:32], flen);
        if (m_n == 0) begin
          chk(desc_data[7:0] == m_addr[7:0] && desc_data[39:32] == 8'(flen), "R5",
              "low bytes first", desc_data[39:32], flen & 8'hFF);
        end
        if (stall && (cyc % 3 == 1)) begin
          desc_ready = 1'b0;
        end else begin
          desc_ready = 1'b1;
          m_addr = m_addr + 32'(flen);
          m_rem  = m_rem - 32'(flen);
          m_n++;
          if (m_rem == 0 || m_n == MAXE) req_valid = 1'b0;
        end
      end
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(done == 1'b0 && err == 1'b0 && req_ready == 1'b1, "R7", "pulse ends, idle",
        {done, err, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(desc_valid == 1'b0, "R1", "desc_valid in reset", desc_valid, 0);
    chk(done == 1'b0 && err == 1'b0, "R1", "done/err in reset", {done, err}, 0);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    rst = 1'b0;

    for (int i = 0; i < 11; i++) begin
      run_case(VEC[i][72:41], VEC[i][40:9], int'(VEC[i][8:3]), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6: long stall holds the record
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_2800; req_len = 32'h0000_3000; desc_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(desc_valid == 1'b1 && desc_data == {32'h0000_0800, 32'h0000_2800}, "R6",
          "stalled record held", desc_data, {32'h0000_0800, 32'h0000_2800});
      @(negedge clk);
    end

    // R1: reset in the middle of a list
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(desc_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "mid-list reset clears",
        {desc_valid, done, err}, 0);
    chk(req_ready == 1'b1, "R1", "mid-list reset idle", req_ready, 1);

    // after reset a fresh request works again
    run_case(32'h0000_3FFE, 32'h0000_0004, 2, 1'b0, 1'b0, 1'b0);

    report();
    $finish;
  end
endmodule